// File: doc/BRIEF.md
# Deferred Floating-Point Exception Dispatch Controller

This block sits beside a floating-point execution unit and holds the exceptions that one instruction detects until a later instruction reports them. It keeps one sticky flag per exception kind, one mask bit per kind and a summary error bit. It watches the class of each instruction offered for issue and decides whether that instruction must be held back because an exception is still pending.

A mode input selects how a pending error is reported. In native mode the block stalls the waiting instruction, sends a one-cycle trap request carrying vector number 16, and keeps the stall until the trap is acknowledged. In external mode it drives an error pin from the summary bit, and stalls waiting instructions only while an external ignore input is low. A group of non-waiting instruction classes never stalls. Some of them discard the pending state, and others leave it for a later waiting instruction to report. Software can load the status and mask registers directly.

Top module: `fpx_defer_ctrl`

## Requirements
- R1: After reset, status_word is all zero, control_word (the masks) is all ones, and trap_req, issue_stall and err_pin are low.
- R2: An exception report (exc_valid high) sets status_word bit i for every set bit i of exc_bits, whatever the masks are. The summary bit status_word[NUM_EXC] is set when at least one reported bit has a clear mask. All these bits stay set until a clear event.
- R3: In native mode (native_mode = 1), an offered instruction of a waiting class (insn_class 0 = arithmetic, 1 = explicit wait, 2 = packed-integer) raises issue_stall in the same cycle while the summary bit is set. In the next cycle trap_req is high for exactly one cycle, with trap_vector = 16.
- R4: Once a trap has been requested, issue_stall stays high until trap_ack is sampled high. In the acknowledge cycle issue_stall is low and the instruction is accepted.
- R5: The non-waiting classes 3 to 8 never raise issue_stall or trap_req, even when an error is pending.
- R6: Class 4 (clear exceptions) clears all flags and the summary bit and keeps the masks. Classes 3 (initialize) and 6 (save state) clear all flags and the summary bit and set all masks. Class 5 (store environment) sets all masks and clears the summary bit, and keeps the flags.
- R7: Classes 7 (store status), 8 (store control) and 9 to 15 (not floating point) leave both registers unchanged, so a waiting instruction that follows still stalls.
- R8: In external mode (native_mode = 0), err_pin equals the summary bit and trap_req stays low. A waiting instruction stalls while the summary bit is set and ext_ignore is low, and it proceeds when ext_ignore is high.
- R9: sw_wr loads status_word from wr_data, with the summary bit at bit NUM_EXC. cw_wr loads the masks from wr_data[NUM_EXC-1:0]. A register write, or an accepted discarding class, takes priority over an exception report in the same cycle.
- R10: A report whose bits are all masked sets the flags only. It leaves the summary bit clear and causes no stall or trap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| exc_valid | input | 1 | An exception report is present this cycle |
| exc_bits | input | NUM_EXC | Exception kinds detected |
| insn_valid | input | 1 | An instruction is offered for issue |
| insn_class | input | 4 | Decoded class of the offered instruction |
| native_mode | input | 1 | 1 = internal trap, 0 = external error pin |
| ext_ignore | input | 1 | External request to ignore the pending error |
| trap_ack | input | 1 | Trap has been taken |
| sw_wr | input | 1 | Load the status register |
| cw_wr | input | 1 | Load the mask register |
| wr_data | input | NUM_EXC+1 | Write data for both registers |
| status_word | output | NUM_EXC+1 | {summary, flags} |
| control_word | output | NUM_EXC | Mask bits |
| issue_stall | output | 1 | Hold the offered instruction |
| trap_req | output | 1 | One-cycle trap request |
| trap_vector | output | 8 | Trap vector number (16) |
| err_pin | output | 1 | External error indication |

## Verification
The bench sweeps every non-zero exception pattern against several mask patterns. A design that set the summary bit for masked kinds, or that dropped a flag of a masked kind, would give a wrong status word. Each of the three waiting classes is driven into a trap, and the bench checks that the request lasts exactly one cycle and that the stall is released only on acknowledge. A design that held the stall too long or retriggered would fail these checks. Each of the six non-waiting classes is offered while an error is pending, and the next waiting instruction then shows whether the pending state was discarded or kept. The bench also covers a report that arrives in the same cycle as a register write, and in external mode it toggles the ignore input.

// File: rtl/fpx_pkg.sv
// Shared types for the deferred exception dispatch controller.
// Assumes a 4-bit decoded instruction class from the front end.
package fpx_pkg;
    localparam int CLS_W = 4;

    typedef enum logic [CLS_W-1:0] {
        CLS_ARITH  = 4'd0,
        CLS_WAIT   = 4'd1,
        CLS_PACKED = 4'd2,
        CLS_INIT   = 4'd3,
        CLS_CLEAR  = 4'd4,
        CLS_STENV  = 4'd5,
        CLS_SAVE   = 4'd6,
        CLS_STSW   = 4'd7,
        CLS_STCW   = 4'd8
    } cls_e;

    // Effect of one instruction class on the exception state
    typedef struct packed {
        logic waiting;    // must report a pending error first
        logic clr_flags;  // wipe sticky flags
        logic clr_es;     // wipe summary bit
        logic set_masks;  // mask every kind
    } cls_fx_t;
endpackage

// File: rtl/fpx_class_decode.sv
// Turns the decoded instruction class into the set of effects it has on
// the exception state. Classes with no listed code have no effect.
module fpx_class_decode
    import fpx_pkg::*;
(
    input  logic [CLS_W-1:0] cls,
    output cls_fx_t          fx
);
    // Map each class to its effects
    always_comb begin
        fx = '0;
        case (cls)
            CLS_ARITH, CLS_WAIT, CLS_PACKED: fx.waiting = 1'b1;
            CLS_INIT, CLS_SAVE: begin
                fx.clr_flags = 1'b1;
                fx.clr_es    = 1'b1;
                fx.set_masks = 1'b1;
            end
            CLS_CLEAR: begin
                fx.clr_flags = 1'b1;
                fx.clr_es    = 1'b1;
            end
            CLS_STENV: begin
                fx.clr_es    = 1'b1;
                fx.set_masks = 1'b1;
            end
            default: fx = '0;
        endcase
    end
endmodule

// File: rtl/fpx_status_regs.sv
// Sticky exception flags, summary bit and mask register.
// Priority: register write, then accepted discarding class, then report.
// Assumes the accept strobe already accounts for the issue stall.
module fpx_status_regs
    import fpx_pkg::*;
#(
    parameter int NUM_EXC = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               exc_valid,
    input  logic [NUM_EXC-1:0] exc_bits,
    input  logic               accept,
    input  cls_fx_t            fx,
    input  logic               sw_wr,
    input  logic               cw_wr,
    input  logic [NUM_EXC:0]   wr_data,
    output logic [NUM_EXC-1:0] flags,
    output logic               es,
    output logic [NUM_EXC-1:0] masks
);
    logic clr_flags_now;
    logic clr_es_now;
    logic unmasked_hit;

    // Decide which clear events apply this cycle
    always_comb begin
        clr_flags_now = accept && fx.clr_flags;
        clr_es_now    = accept && fx.clr_es;
        unmasked_hit  = exc_valid && (|(exc_bits & ~masks));
    end

    // One sticky flag per exception kind
    for (genvar i = 0; i < NUM_EXC; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                flags[i] <= 1'b0;
            end else if (sw_wr) begin
                flags[i] <= wr_data[i];
            end else if (clr_flags_now) begin
                flags[i] <= 1'b0;
            end else if (!clr_es_now && exc_valid && exc_bits[i]) begin
                flags[i] <= 1'b1;
            end
        end
    end

    // Summary error bit, set only by unmasked reports
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            es <= 1'b0;
        end else if (sw_wr) begin
            es <= wr_data[NUM_EXC];
        end else if (clr_es_now) begin
            es <= 1'b0;
        end else if (unmasked_hit) begin
            es <= 1'b1;
        end
    end

    // Mask register, all kinds masked out of reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            masks <= '1;
        end else if (cw_wr) begin
            masks <= wr_data[NUM_EXC-1:0];
        end else if (accept && fx.set_masks) begin
            masks <= '1;
        end
    end
endmodule

// File: rtl/fpx_trap_seq.sv
// Issue hold and trap request sequencer. In native mode a waiting
// instruction that meets a pending error raises a one-cycle trap request
// and is held until the acknowledge. In external mode the instruction is
// held while the error is pending and the ignore input is low.
module fpx_trap_seq #(
    parameter int VEC_W  = 8,
    parameter int VECTOR = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             insn_valid,
    input  logic             waiting,
    input  logic             es,
    input  logic             native_mode,
    input  logic             ext_ignore,
    input  logic             trap_ack,
    output logic             issue_stall,
    output logic             trap_req,
    output logic [VEC_W-1:0] trap_vector,
    output logic             held
);
    typedef enum logic {SEQ_IDLE, SEQ_HELD} seq_e;

    seq_e state;
    logic hit;
    logic fire;

    assign trap_vector = VEC_W'(VECTOR);
    assign held        = (state == SEQ_HELD);

    // Detect a waiting instruction meeting a pending error
    always_comb begin
        hit  = insn_valid && waiting && es;
        fire = (state == SEQ_IDLE) && hit && native_mode;
        if (state == SEQ_HELD) begin
            issue_stall = !trap_ack;
        end else begin
            issue_stall = hit && (native_mode || !ext_ignore);
        end
    end

    // Hold state until the trap is acknowledged
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= SEQ_IDLE;
        end else if (fire) begin
            state <= SEQ_HELD;
        end else if (state == SEQ_HELD && trap_ack) begin
            state <= SEQ_IDLE;
        end
    end

    // One-cycle trap request pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trap_req <= 1'b0;
        end else begin
            trap_req <= fire;
        end
    end
endmodule

// File: rtl/fpx_defer_ctrl.sv
// Top of the deferred exception dispatch controller. Ties the class
// decoder, the status registers and the trap sequencer together and
// drives the external error pin. Assumes one offered instruction at a
// time, held on the inputs while issue_stall is high.
module fpx_defer_ctrl
    import fpx_pkg::*;
#(
    parameter int NUM_EXC = 6,
    parameter int VEC_W   = 8,
    parameter int VECTOR  = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               exc_valid,
    input  logic [NUM_EXC-1:0] exc_bits,
    input  logic               insn_valid,
    input  logic [CLS_W-1:0]   insn_class,
    input  logic               native_mode,
    input  logic               ext_ignore,
    input  logic               trap_ack,
    input  logic               sw_wr,
    input  logic               cw_wr,
    input  logic [NUM_EXC:0]   wr_data,
    output logic [NUM_EXC:0]   status_word,
    output logic [NUM_EXC-1:0] control_word,
    output logic               issue_stall,
    output logic               trap_req,
    output logic [VEC_W-1:0]   trap_vector,
    output logic               err_pin
);
    cls_fx_t            fx;
    logic [NUM_EXC-1:0] flags;
    logic               es;
    logic               accept;
    logic               seq_held;

    fpx_class_decode dec_i (
        .cls (insn_class),
        .fx  (fx)
    );

    fpx_status_regs #(.NUM_EXC(NUM_EXC)) regs_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .exc_valid (exc_valid),
        .exc_bits  (exc_bits),
        .accept    (accept),
        .fx        (fx),
        .sw_wr     (sw_wr),
        .cw_wr     (cw_wr),
        .wr_data   (wr_data),
        .flags     (flags),
        .es        (es),
        .masks     (control_word)
    );

    fpx_trap_seq #(.VEC_W(VEC_W), .VECTOR(VECTOR)) seq_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .insn_valid  (insn_valid),
        .waiting     (fx.waiting),
        .es          (es),
        .native_mode (native_mode),
        .ext_ignore  (ext_ignore),
        .trap_ack    (trap_ack),
        .issue_stall (issue_stall),
        .trap_req    (trap_req),
        .trap_vector (trap_vector),
        .held        (seq_held)
    );

    // Instruction acceptance, register view and external pin
    always_comb begin
        accept      = insn_valid && !issue_stall;
        status_word = {es, flags};
        err_pin     = es && !native_mode;
    end
endmodule

// File: rtl/fpx_defer_chk.sv
// Property checker for fpx_defer_ctrl, attached by bind below.
module fpx_defer_chk #(
    parameter int NUM_EXC = 6,
    parameter int VEC_W   = 8,
    parameter int VECTOR  = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               exc_valid,
    input logic [NUM_EXC-1:0] exc_bits,
    input logic               insn_valid,
    input logic [3:0]         insn_class,
    input logic               native_mode,
    input logic               trap_ack,
    input logic               sw_wr,
    input logic [NUM_EXC:0]   status_word,
    input logic [NUM_EXC-1:0] control_word,
    input logic               issue_stall,
    input logic               trap_req,
    input logic [VEC_W-1:0]   trap_vector,
    input logic               err_pin,
    input logic               held
);
    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (status_word == '0 && control_word == '1 && !trap_req));

    // R3
    trap_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |=> !trap_req);

    // R3
    trap_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |-> $past(insn_valid && native_mode && status_word[NUM_EXC]
                           && insn_class <= 4'd2));

    // R3
    trap_vector_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |-> trap_vector == VEC_W'(VECTOR));

    // R4
    hold_until_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (held && !trap_ack) |-> issue_stall);

    // R5
    nonwait_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (insn_valid && insn_class >= 4'd3 && insn_class <= 4'd8 && !held)
            |-> !issue_stall);

    // R8
    err_pin_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_pin |-> (!native_mode && status_word[NUM_EXC]));

    // R10
    masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_valid && (exc_bits & ~control_word) == '0
         && !status_word[NUM_EXC] && !sw_wr) |=> !status_word[NUM_EXC]);
endmodule

bind fpx_defer_ctrl fpx_defer_chk #(
    .NUM_EXC (NUM_EXC),
    .VEC_W   (VEC_W),
    .VECTOR  (VECTOR)
) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .exc_valid    (exc_valid),
    .exc_bits     (exc_bits),
    .insn_valid   (insn_valid),
    .insn_class   (insn_class),
    .native_mode  (native_mode),
    .trap_ack     (trap_ack),
    .sw_wr        (sw_wr),
    .status_word  (status_word),
    .control_word (control_word),
    .issue_stall  (issue_stall),
    .trap_req     (trap_req),
    .trap_vector  (trap_vector),
    .err_pin      (err_pin),
    .held         (seq_held)
);

// File: tb/fpx_defer_ctrl_tb.sv
module fpx_defer_ctrl_tb_top;
    localparam int NE = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          exc_valid = 1'b0;
    logic [NE-1:0] exc_bits = '0;
    logic          insn_valid = 1'b0;
    logic [3:0]    insn_class = '0;
    logic          native_mode = 1'b1;
    logic          ext_ignore = 1'b0;
    logic          trap_ack = 1'b0;
    logic          sw_wr = 1'b0;
    logic          cw_wr = 1'b0;
    logic [NE:0]   wr_data = '0;
    logic [NE:0]   status_word;
    logic [NE-1:0] control_word;
    logic          issue_stall;
    logic          trap_req;
    logic [7:0]    trap_vector;
    logic          err_pin;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    fpx_defer_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .exc_valid(exc_valid), .exc_bits(exc_bits),
        .insn_valid(insn_valid), .insn_class(insn_class),
        .native_mode(native_mode), .ext_ignore(ext_ignore),
        .trap_ack(trap_ack), .sw_wr(sw_wr), .cw_wr(cw_wr), .wr_data(wr_data),
        .status_word(status_word), .control_word(control_word),
        .issue_stall(issue_stall), .trap_req(trap_req),
        .trap_vector(trap_vector), .err_pin(err_pin)
    );

    task automatic chk(input int act, input int exp, input string tag);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic write_sw(input int v);
        sw_wr = 1'b1; wr_data = (NE+1)'(v);
        tick();
        sw_wr = 1'b0;
    endtask

    task automatic write_cw(input int v);
        cw_wr = 1'b1; wr_data = (NE+1)'(v);
        tick();
        cw_wr = 1'b0;
    endtask

    task automatic offer(input int cls);
        insn_valid = 1'b1; insn_class = 4'(cls);
        #1;
    endtask

    // Run a trap to completion from an offered waiting instruction
    task automatic finish_trap(input string tag);
        chk(issue_stall, 1, {tag, " stall on hit"});
        tick();
        chk(trap_req, 1, {tag, " trap_req pulse"});
        chk(trap_vector, 16, {tag, " vector"});
        chk(issue_stall, 1, {tag, " stall while pending"});
        tick();
        chk(trap_req, 0, {tag, " trap_req one cycle"});
        chk(issue_stall, 1, {tag, " stall before ack"});
        trap_ack = 1'b1;
        #1;
        chk(issue_stall, 0, {tag, " release on ack"});
        tick();
        trap_ack = 1'b0; insn_valid = 1'b0;
        #1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        int mpat[4];
        int exp_sw [16];
        int exp_cw [16];
        mpat[0] = 'h00; mpat[1] = 'h3F; mpat[2] = 'h15; mpat[3] = 'h2A;

        repeat (3) tick();
        rst_n = 1'b1;
        #1;
        // R1 reset state
        chk(status_word, 0, "R1 status after reset");
        chk(control_word, 'h3F, "R1 masks after reset");
        chk(trap_req, 0, "R1 trap_req after reset");
        chk(err_pin, 0, "R1 err_pin after reset");
        chk(issue_stall, 0, "R1 stall after reset");

        // R2 / R10 sweep of every pattern over several masks
        for (int m = 0; m < 4; m++) begin
            for (int b = 1; b < 64; b++) begin
                write_cw(mpat[m]);
                write_sw(0);
                exc_valid = 1'b1; exc_bits = NE'(b);
                tick();
                exc_valid = 1'b0;
                chk(status_word, (((b & ~mpat[m] & 'h3F) != 0) ? 'h40 : 0) | b,
                    "R2 R10 report sweep");
            end
        end

        // R2 sticky accumulation
        write_cw('h3F); write_sw(0);
        exc_valid = 1'b1; exc_bits = 6'h01; tick();
        exc_bits = 6'h04; tick();
        exc_valid = 1'b0;
        chk(status_word, 'h05, "R2 flags sticky");

        // R10 masked error does not stall a waiting instruction
        native_mode = 1'b1;
        offer(0);
        chk(issue_stall, 0, "R10 masked no stall");
        tick();
        chk(trap_req, 0, "R10 masked no trap");
        insn_valid = 1'b0;

        // R9 register write beats a report in the same cycle
        write_cw(0);
        sw_wr = 1'b1; wr_data = 7'h08; exc_valid = 1'b1; exc_bits = 6'h01;
        tick();
        sw_wr = 1'b0; exc_valid = 1'b0;
        chk(status_word, 'h08, "R9 write over report");
        // R9 clear class beats a report in the same cycle
        write_sw('h41);
        insn_valid = 1'b1; insn_class = 4'd4; exc_valid = 1'b1; exc_bits = 6'h02;
        tick();
        insn_valid = 1'b0; exc_valid = 1'b0;
        chk(status_word, 0, "R9 clear over report");
        write_cw('h2A);
        chk(control_word, 'h2A, "R9 mask write");

        // R3 / R4 each waiting class traps in native mode
        for (int c = 0; c < 3; c++) begin
            write_cw(0);
            write_sw('h41);
            offer(c);
            finish_trap("R3 R4 waiting class");
        end

        // R5 / R6 / R7 non-waiting classes with an error pending
        exp_sw[3] = 'h00; exp_cw[3] = 'h3F;
        exp_sw[4] = 'h00; exp_cw[4] = 'h00;
        exp_sw[5] = 'h02; exp_cw[5] = 'h3F;
        exp_sw[6] = 'h00; exp_cw[6] = 'h3F;
        exp_sw[7] = 'h42; exp_cw[7] = 'h00;
        exp_sw[8] = 'h42; exp_cw[8] = 'h00;
        exp_sw[9] = 'h42; exp_cw[9] = 'h00;
        for (int c = 3; c < 10; c++) begin
            write_cw(0);
            write_sw('h42);
            offer(c);
            chk(issue_stall, 0, "R5 non-waiting no stall");
            tick();
            insn_valid = 1'b0;
            chk(trap_req, 0, "R5 non-waiting no trap");
            chk(status_word, exp_sw[c], "R6 R7 status after class");
            chk(control_word, exp_cw[c], "R6 R7 masks after class");
            offer(0);
            if ((exp_sw[c] & 'h40) != 0) begin
                finish_trap("R7 kept error traps later");
            end else begin
                chk(issue_stall, 0, "R6 discarded error no stall");
                tick();
                insn_valid = 1'b0;
            end
        end

        // R8 external mode
        native_mode = 1'b0;
        write_cw(0);
        write_sw('h41);
        chk(err_pin, 1, "R8 err_pin follows summary");
        offer(1);
        chk(issue_stall, 1, "R8 stall without ignore");
        tick();
        chk(trap_req, 0, "R8 no trap in external mode");
        chk(issue_stall, 1, "R8 stall holds");
        ext_ignore = 1'b1;
        #1;
        chk(issue_stall, 0, "R8 ignore lets instruction pass");
        ext_ignore = 1'b0;
        #1;
        chk(issue_stall, 1, "R8 stall back without ignore");
        write_sw(0);
        chk(issue_stall, 0, "R8 stall drops once cleared");
        chk(err_pin, 0, "R8 err_pin low once cleared");
        insn_valid = 1'b0;

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule